// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block keeps a set of event counters for a MAC. Each counter has its own strobe input. A frame counter adds one for every cycle its strobe is high. An octet counter adds the byte count that comes with its strobe. Which lanes count octets is chosen by a parameter bit mask. The live counters are `CNT_W` bits wide (40 by default) and wrap modulo 2^CNT_W.

A 16-bit register port lets the host work with the bank. One command bit copies every live counter into its holding register on the same clock edge, so all values the host then reads come from one instant. Another command bit zeroes every live counter at once. Each counter has a wrap flag that clears when it is read, so software can extend the count past `CNT_W` bits. An interrupt output is raised when a flag is set and its mask bit is set. With all masks at zero the host simply polls.

The address map is fixed:

| Address | Contents |
|---|---|
| 0x00 | Command register |
| 0x04–0x07 | Wrap flag words |
| 0x08–0x0B | Mask words |
| 0x10 + 4·i | Counter i, three readable words |

Host reads are registered and return data on the cycle after the request.

Top module: `stat_snap_bank`

## Requirements
- R1: For a frame lane, a cycle with its strobe high adds 1 to the live counter. For an octet lane (`OCTET_MASK` bit set), it adds that lane's `evt_bytes` field. Counters wrap modulo 2^CNT_W.
- R2: Counter i is read at three addresses from 0x10 + 4·i. Offset +0 gives bits 15:0, offset +1 gives bits 31:16, and offset +2 gives bits CNT_W-1:32 in its low bits, zero-extended. Offset +3 reads 0.
- R3: A write to address 0x00 with bit 0 set copies every live counter into its holding register on that clock edge. If bit 1 is set in the same write, the copy holds the values from before the clear.
- R4: Holding registers change only on a snapshot command. Live counters keep counting while a snapshot is held.
- R5: A write to address 0x00 with bit 1 set zeroes every live counter on that clock edge. An event in that same cycle is dropped.
- R6: A counter that wraps past 2^CNT_W-1 sets its wrap flag. The flag for counter 16·k + j is bit j of the word at address 0x04 + k.
- R7: Reading a wrap flag word clears the flags it returned. A wrap that happens in the same cycle as that read leaves its flag set.
- R8: Mask bits sit at 0x08 + k, in the same layout as the flags. `irq` is registered and goes high one cycle after any flag and its mask bit are both set. With all masks zero, `irq` stays low.
- R9: The command register always reads 0, because its bits are single-cycle pulses. Addresses that are not mapped also read 0.
- R10: After reset, all live counters, holding registers, flags and masks are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_strobe | input | NUM_CNT | Per-lane event strobe |
| evt_bytes | input | NUM_CNT*INC_W | Per-lane byte count; lane i is in bits [i*INC_W +: INC_W] |
| host_wr_en | input | 1 | Host write request |
| host_rd_en | input | 1 | Host read request |
| host_addr | input | ADDR_W | Host register address |
| host_wr_data | input | 16 | Host write data |
| host_rd_data | output | 16 | Registered read data, valid the cycle after `host_rd_en` |
| irq | output | 1 | Masked wrap interrupt |

## Verification
The assertions check the following on every cycle:
- A clear leaves every live counter at zero.
- A snapshot copies the live value exactly.
- Holding registers stay still without a snapshot.
- A wrap always makes the count smaller.
- No flag rises without a wrap, and every wrap leaves its flag set.
- `irq` stays low when no mask bit is set.
- The command register reads as zero.

Some behaviour can only be shown by the bench scenarios. These are:
- the word layout of a large count;
- freezing across later events;
- snapshot and clear in the same write;
- clear-on-read of a flag word that races with a new wrap;
- the 40-bit carry itself.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int HOST_W        = 16;
  localparam int FLAG_W        = 64;
  localparam int ADDR_CMD      = 'h00;
  localparam int ADDR_ROLL     = 'h04;
  localparam int ADDR_MASK     = 'h08;
  localparam int ADDR_CNT      = 'h10;
  localparam int CMD_SNAP_BIT  = 0;
  localparam int CMD_CLR_BIT   = 1;

  typedef enum logic [1:0] {
    WORD_LO   = 2'd0,
    WORD_MID  = 2'd1,
    WORD_HI   = 2'd2,
    WORD_NONE = 2'd3
  } cnt_word_e;
endpackage

// File: rtl/stat_counter_lane.sv
module stat_counter_lane #(
  parameter int CNT_W    = 40,
  parameter int INC_W    = 16,
  parameter bit IS_OCTET = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic [INC_W-1:0] bytes,
  input  logic             snap,
  input  logic             clr,
  output logic [CNT_W-1:0] hold,
  output logic             wrap
);
  logic [CNT_W-1:0] live;
  logic [CNT_W-1:0] step;
  logic [CNT_W:0]   sum;

  generate
    if (IS_OCTET) begin : g_octet
      assign step = CNT_W'(bytes);
    end else begin : g_frame
      logic bytes_unused;
      assign bytes_unused = ^bytes;
      assign step = CNT_W'(1);
    end
  endgenerate

  assign sum  = {1'b0, live} + {1'b0, step};
  assign wrap = evt & ~clr & sum[CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      hold <= '0;
    end else begin
      if (snap) hold <= live;
      if (clr)      live <= '0;
      else if (evt) live <= sum[CNT_W-1:0];
    end
  end

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> live == '0);
  assert_snap_copy_R3: assert property (@(posedge clk) disable iff (rst)
    snap |=> hold == $past(live));
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !snap |=> $stable(hold));
  assert_wrap_drop_R1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> live < $past(live));
endmodule

// File: rtl/stat_wrap_flags.sv
module stat_wrap_flags
  import stat_bank_pkg::*;
#(
  parameter int NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] wrap_in,
  input  logic               rd_clr,
  input  logic [1:0]         rd_sel,
  input  logic               mask_we,
  input  logic [1:0]         mask_sel,
  input  logic [HOST_W-1:0]  mask_data,
  output logic [FLAG_W-1:0]  flags,
  output logic [FLAG_W-1:0]  masks,
  output logic               irq
);
  logic [FLAG_W-1:0] wrap_pad;
  logic [FLAG_W-1:0] clr_vec;

  assign wrap_pad = FLAG_W'(wrap_in);
  assign clr_vec  = rd_clr ? (FLAG_W'(16'hFFFF) << {rd_sel, 4'b0000}) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      masks <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr_vec) | wrap_pad;
      if (mask_we) masks[{mask_sel, 4'b0000} +: HOST_W] <= mask_data;
      irq <= |(flags & masks);
    end
  end

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    (|wrap_pad) |=> ((flags & $past(wrap_pad)) == $past(wrap_pad)));
  assert_flag_source_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(wrap_pad)) == '0));
  assert_no_irq_unmasked_R8: assert property (@(posedge clk) disable iff (rst)
    (masks == '0) |=> !irq);
endmodule

// File: rtl/stat_host_port.sv
module stat_host_port
  import stat_bank_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 40,
  parameter int ADDR_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [HOST_W-1:0]               wr_data,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   hold,
  input  logic [FLAG_W-1:0]               flags,
  input  logic [FLAG_W-1:0]               masks,
  output logic                            snap_pulse,
  output logic                            clr_pulse,
  output logic                            roll_rd,
  output logic [1:0]                      roll_sel,
  output logic                            mask_we,
  output logic [1:0]                      mask_sel,
  output logic [HOST_W-1:0]               rd_data
);
  logic              hit_cmd, hit_roll, hit_mask, hit_cnt;
  logic [ADDR_W-1:0] cnt_off;
  cnt_word_e         word;
  logic [47:0]       sel_ext;
  logic              sel_ok;
  logic [HOST_W-1:0] rd_next;

  assign hit_cmd  = addr == ADDR_W'(ADDR_CMD);
  assign hit_roll = addr[ADDR_W-1:2] == (ADDR_W-2)'(ADDR_ROLL >> 2);
  assign hit_mask = addr[ADDR_W-1:2] == (ADDR_W-2)'(ADDR_MASK >> 2);
  assign hit_cnt  = addr >= ADDR_W'(ADDR_CNT);
  assign cnt_off  = addr - ADDR_W'(ADDR_CNT);
  assign word     = cnt_word_e'(cnt_off[1:0]);

  assign snap_pulse = wr_en & hit_cmd & wr_data[CMD_SNAP_BIT];
  assign clr_pulse  = wr_en & hit_cmd & wr_data[CMD_CLR_BIT];
  assign roll_rd    = rd_en & hit_roll;
  assign roll_sel   = addr[1:0];
  assign mask_we    = wr_en & hit_mask;
  assign mask_sel   = addr[1:0];

  always_comb begin
    sel_ext = '0;
    sel_ok  = 1'b0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (int'(cnt_off[ADDR_W-1:2]) == i) begin
        sel_ext = 48'(hold[i]);
        sel_ok  = 1'b1;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (hit_roll)      rd_next = flags[{addr[1:0], 4'b0000} +: HOST_W];
    else if (hit_mask) rd_next = masks[{addr[1:0], 4'b0000} +: HOST_W];
    else if (hit_cnt && sel_ok) begin
      case (word)
        WORD_LO:  rd_next = sel_ext[15:0];
        WORD_MID: rd_next = sel_ext[31:16];
        WORD_HI:  rd_next = sel_ext[47:32];
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assert_cmd_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hit_cmd) |=> rd_data == '0);
endmodule

// File: rtl/stat_snap_bank.sv
module stat_snap_bank
  import stat_bank_pkg::*;
#(
  parameter int                 NUM_CNT    = 8,
  parameter int                 CNT_W      = 40,
  parameter int                 INC_W      = 16,
  parameter int                 ADDR_W     = 8,
  parameter logic [NUM_CNT-1:0] OCTET_MASK = NUM_CNT'(5)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CNT-1:0]       evt_strobe,
  input  logic [NUM_CNT*INC_W-1:0] evt_bytes,
  input  logic                     host_wr_en,
  input  logic                     host_rd_en,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [15:0]              host_wr_data,
  output logic [15:0]              host_rd_data,
  output logic                     irq
);
  localparam int MAX_CNT = ((1 << ADDR_W) - ADDR_CNT) / 4;

  initial begin
    if (CNT_W <= 32 || CNT_W > 48) $error("CNT_W must be in 33..48");
    if (INC_W > CNT_W)             $error("INC_W must not exceed CNT_W");
    if (NUM_CNT > MAX_CNT || NUM_CNT > FLAG_W) $error("NUM_CNT too large for map");
  end

  logic [NUM_CNT-1:0][CNT_W-1:0] hold_arr;
  logic [NUM_CNT-1:0]            wrap_vec;
  logic                          snap_pulse, clr_pulse, roll_rd, mask_we;
  logic [1:0]                    roll_sel, mask_sel;
  logic [FLAG_W-1:0]             flags, masks;

  genvar g;
  generate
    for (g = 0; g < NUM_CNT; g++) begin : g_lane
      stat_counter_lane #(
        .CNT_W   (CNT_W),
        .INC_W   (INC_W),
        .IS_OCTET(OCTET_MASK[g])
      ) lane_i (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt_strobe[g]),
        .bytes(evt_bytes[g*INC_W +: INC_W]),
        .snap (snap_pulse),
        .clr  (clr_pulse),
        .hold (hold_arr[g]),
        .wrap (wrap_vec[g])
      );
    end
  endgenerate

  stat_wrap_flags #(.NUM_CNT(NUM_CNT)) flags_i (
    .clk      (clk),
    .rst      (rst),
    .wrap_in  (wrap_vec),
    .rd_clr   (roll_rd),
    .rd_sel   (roll_sel),
    .mask_we  (mask_we),
    .mask_sel (mask_sel),
    .mask_data(host_wr_data),
    .flags    (flags),
    .masks    (masks),
    .irq      (irq)
  );

  stat_host_port #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) host_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (host_wr_en),
    .rd_en     (host_rd_en),
    .addr      (host_addr),
    .wr_data   (host_wr_data),
    .hold      (hold_arr),
    .flags     (flags),
    .masks     (masks),
    .snap_pulse(snap_pulse),
    .clr_pulse (clr_pulse),
    .roll_rd   (roll_rd),
    .roll_sel  (roll_sel),
    .mask_we   (mask_we),
    .mask_sel  (mask_sel),
    .rd_data   (host_rd_data)
  );
endmodule

// File: tb/stat_snap_bank_tb.sv
module stat_snap_bank_tb_top;
  localparam int N  = 8;
  localparam int IW = 24;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    evt_strobe = '0;
  logic [N*IW-1:0] evt_bytes = '0;
  logic            host_wr_en = 1'b0;
  logic            host_rd_en = 1'b0;
  logic [AW-1:0]   host_addr = '0;
  logic [15:0]     host_wr_data = '0;
  logic [15:0]     host_rd_data;
  logic            irq;

  int vec_cnt  = 0;
  int miss_cnt = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  stat_snap_bank #(
    .NUM_CNT(N), .CNT_W(40), .INC_W(IW), .ADDR_W(AW), .OCTET_MASK(8'h05)
  ) dut_i (
    .clk(clk), .rst(rst), .evt_strobe(evt_strobe), .evt_bytes(evt_bytes),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wr_data(host_wr_data), .host_rd_data(host_rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    vec_cnt++;
    if (got !== exp) begin
      miss_cnt++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0; host_wr_data = '0;
  endtask

  task automatic host_read(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rd_data;
  endtask

  task automatic read_counter(input int i, output logic [39:0] v);
    logic [15:0] w0, w1, w2;
    host_read(AW'(16 + 4*i), w0);
    host_read(AW'(16 + 4*i + 1), w1);
    host_read(AW'(16 + 4*i + 2), w2);
    v = {w2[7:0], w1, w0};
  endtask

  task automatic events(input logic [N-1:0] m, input logic [IW-1:0] b, input int cycles);
    @(negedge clk);
    evt_strobe = m;
    for (int i = 0; i < N; i++) evt_bytes[i*IW +: IW] = b;
    repeat (cycles) @(negedge clk);
    evt_strobe = '0;
    evt_bytes  = '0;
  endtask

  task automatic t_reset;
    logic [39:0] v;
    logic [15:0] d;
    read_counter(0, v); check("R10 hold0 after reset", 64'(v), 0);
    host_write(8'h00, 16'h0001);
    read_counter(1, v); check("R10 live1 after reset", 64'(v), 0);
    host_read(8'h04, d); check("R10 flags after reset", 64'(d), 0);
    host_read(8'h08, d); check("R10 masks after reset", 64'(d), 0);
    check("R10 irq after reset", 64'(irq), 0);
  endtask

  task automatic t_counting;
    logic [39:0] v;
    events(8'h02, 24'd0, 5);
    events(8'h01, 24'd100, 1);
    events(8'h01, 24'd200, 1);
    host_write(8'h00, 16'h0001);
    read_counter(1, v); check("R1 frame count", 64'(v), 5);
    read_counter(0, v); check("R1 octet count", 64'(v), 300);
  endtask

  task automatic t_freeze;
    logic [39:0] v;
    events(8'h02, 24'd0, 3);
    read_counter(1, v); check("R4 hold frozen", 64'(v), 5);
    host_write(8'h00, 16'h0001);
    read_counter(1, v); check("R3 new snapshot", 64'(v), 8);
  endtask

  task automatic t_misc_reads;
    logic [15:0] d;
    host_write(8'h00, 16'h0003);
    host_read(8'h00, d); check("R9 command reads zero", 64'(d), 0);
    host_read(8'h13, d); check("R2 word 3 reads zero", 64'(d), 0);
    host_read(8'h0F, d); check("R9 unmapped reads zero", 64'(d), 0);
  endtask

  task automatic t_clear;
    logic [39:0] v;
    events(8'h02, 24'd0, 2);
    host_write(8'h00, 16'h0003);
    read_counter(1, v); check("R3 snap with clear keeps old", 64'(v), 2);
    host_write(8'h00, 16'h0001);
    read_counter(1, v); check("R5 clear zeroes live", 64'(v), 0);
    read_counter(0, v); check("R5 clear zeroes octet", 64'(v), 0);
  endtask

  task automatic t_wrap;
    logic [39:0] v;
    logic [15:0] d;
    events(8'h05, 24'hFFFFFF, 65536);
    host_write(8'h00, 16'h0001);
    host_read(8'h10, d); check("R2 word lo", 64'(d), 16'h0000);
    host_read(8'h11, d); check("R2 word mid", 64'(d), 16'hFFFF);
    host_read(8'h12, d); check("R2 word hi", 64'(d), 16'h00FF);
    host_read(8'h04, d); check("R6 no flag before wrap", 64'(d), 0);
    events(8'h01, 24'hFFFFFF, 1);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = 8'h04;
    evt_strobe = 8'h04; evt_bytes[2*IW +: IW] = 24'hFFFFFF;
    @(negedge clk);
    host_rd_en = 1'b0; evt_strobe = '0; evt_bytes = '0;
    d = host_rd_data;
    check("R6 flag0 after wrap", 64'(d), 16'h0001);
    host_write(8'h08, 16'h0000);
    @(negedge clk);
    check("R8 irq low with masks zero", 64'(irq), 0);
    host_write(8'h08, 16'h0004);
    @(negedge clk);
    check("R8 irq high when masked flag", 64'(irq), 1);
    host_read(8'h04, d); check("R7 race wrap kept set", 64'(d), 16'h0004);
    @(negedge clk);
    check("R8 irq drops after clear", 64'(irq), 0);
    host_read(8'h04, d); check("R7 flags cleared by read", 64'(d), 0);
    host_write(8'h00, 16'h0001);
    read_counter(0, v); check("R1 wrapped value lane0", 64'(v), 40'hFEFFFF);
    read_counter(2, v); check("R1 wrapped value lane2", 64'(v), 40'hFEFFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vec_cnt++; miss_cnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_counting();
    t_freeze();
    t_misc_reads();
    t_clear();
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end
endmodule